// File: doc/BRIEF.md
# Modem Control and Status Unit with Loopback

This block keeps the modem control word of a serial port and turns it into the active-low modem output pins. It also watches the four active-low modem inputs (clear-to-send, data-set-ready, ring indicator, carrier detect). Each input passes through a synchronizer chain. The unit keeps sticky change flags for each input and raises a modem status interrupt from them.

A loopback bit lets the port test itself. While it is set, the transmit serial stream is turned back into the receive path and the outward pins go idle. The four status lines then follow the low four control bits, so software can provoke status changes and interrupts by writing the control word. Two flow-control bits are also kept here. One hands the request-to-send pin to the receive buffer. The other holds back the transmitter while clear-to-send is inactive. The serial shifters sit outside this unit.

Top module: `modem_ctl_lb`

## Requirements
- R1: After reset the control word reads 0x00, the status word reads 0x00, `dtr_n` and `rts_n` are 1 and `irq` is 0.
- R2: A control write stores bits 0 (DTR), 1 (RTS), 2 and 3 (auxiliary loopback lines), 4 (loopback), 6 (auto-RTS) and 7 (auto-CTS). Bit 5 always reads 0. When auto-RTS is set, read bit 1 shows the live RTS state, which is `~rx_hold`.
- R3: With loopback clear, `dtr_n` is the inverse of control bit 0 and `rts_n` is the inverse of the RTS state, `txd_pin` equals `txd_core` and `rxd_core` equals `rxd_pin`.
- R4: With loopback set, `rxd_core` equals `txd_core`, `rxd_pin` has no effect and `txd_pin` is 1.
- R5: With loopback set, `dtr_n` and `rts_n` are 1 and the modem input pins are ignored. Status bits are: 4 (CTS) = control bit 1, 5 (DSR) = control bit 0, 6 (RI) = control bit 2, 7 (DCD) = control bit 3.
- R6: With loopback clear, status bits 4, 5, 6 and 7 show 1 when `cts_n`, `dsr_n`, `ri_n` and `dcd_n` respectively are low. A pin change appears SYNC_STAGES+1 cycles after it is sampled.
- R7: Status bit 0 sets on any CTS change, bit 1 on any DSR change and bit 3 on any DCD change. Bit 2 sets only when RI goes from active to inactive. All four flags are sticky.
- R8: A one-cycle `sts_rd` pulse clears status bits 3:0 at the next clock edge.
- R9: `irq` is 1 only when `msi_en` is 1 and a qualifying flag is set. With auto-CTS clear, any of status bits 3:0 qualifies. With auto-CTS set, bit 0 qualifies only when `cts_ie` is 1, while bits 1 to 3 always qualify.
- R10: With auto-CTS set, a CTS change still sets status bit 0.
- R11: With auto-RTS set and loopback clear, `rts_n` equals `rx_hold`.
- R12: `tx_ok` is 1 while auto-CTS is clear. While auto-CTS is set, `tx_ok` equals status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word read value |
| sts_rd | input | 1 | Status read strobe, clears change flags |
| sts_rdata | output | 8 | Status word: lines in 7:4, change flags in 3:0 |
| msi_en | input | 1 | Modem status interrupt enable |
| cts_ie | input | 1 | CTS interrupt enable used under auto-CTS |
| rx_hold | input | 1 | Receive buffer asks the sender to pause |
| txd_core | input | 1 | Serial data from the transmitter |
| rxd_core | output | 1 | Serial data to the receiver |
| txd_pin | output | 1 | Serial data pin out |
| rxd_pin | input | 1 | Serial data pin in |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| irq | output | 1 | Modem status interrupt |
| tx_ok | output | 1 | Transmitter may start the next character |

## Verification
The bench builds the unit with SYNC_STAGES=2 and AUTO_FLOW=1. This keeps the flow-control bits live, so the auto-RTS pin handover, the CTS interrupt gating and `tx_ok` can all be reached. With the short synchronizer, a pin change settles in three cycles. That leaves room for many random mixes of pin changes, control writes and status reads, including switches into and out of loopback. Directed cases cover the ring indicator in both edge directions and a CTS change under auto-CTS with and without `cts_ie`.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // line order matches status bits 7:4 (bit 0 of the struct = CTS)
   typedef struct packed {
      logic dcd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_lines_t;

   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_AUXA = 2;
   localparam int CB_AUXB = 3;
   localparam int CB_LOOP = 4;
   localparam int CB_ARTS = 6;
   localparam int CB_ACTS = 7;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int STAGES = 2,
   parameter int W      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
   import mdm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  mdm_lines_t cur,
   input  logic       clr,
   output mdm_lines_t lines_q,
   output logic [3:0] delta_q
);
   logic [3:0] evt;

   always_comb begin
      evt[0] = cur.cts ^ lines_q.cts;
      evt[1] = cur.dsr ^ lines_q.dsr;
      evt[2] = lines_q.ri & ~cur.ri;   // active to inactive only
      evt[3] = cur.dcd ^ lines_q.dcd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= '0;
         delta_q <= '0;
      end else begin
         lines_q <= cur;
         delta_q <= (delta_q & ~{4{clr}}) | evt;
      end
   end
endmodule

// File: rtl/mdm_irq.sv
module mdm_irq (
   input  logic       msi_en,
   input  logic       cts_ie,
   input  logic       auto_cts,
   input  logic [3:0] delta,
   output logic       irq
);
   logic cts_qual;

   always_comb begin
      cts_qual = delta[0] & (~auto_cts | cts_ie);
      irq      = msi_en & (cts_qual | (|delta[3:1]));
   end
endmodule

// File: rtl/modem_ctl_lb.sv
module modem_ctl_lb
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit AUTO_FLOW   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_wdata,
   output logic [7:0] ctl_rdata,
   input  logic       sts_rd,
   output logic [7:0] sts_rdata,
   input  logic       msi_en,
   input  logic       cts_ie,
   input  logic       rx_hold,
   input  logic       txd_core,
   output logic       rxd_core,
   output logic       txd_pin,
   input  logic       rxd_pin,
   output logic       dtr_n,
   output logic       rts_n,
   input  logic       cts_n,
   input  logic       dsr_n,
   input  logic       ri_n,
   input  logic       dcd_n,
   output logic       irq,
   output logic       tx_ok
);
   localparam logic [7:0] WMASK = AUTO_FLOW ? 8'hDF : 8'h1F;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [7:0]  ctl_q;
   logic        loop_on, auto_cts, rts_act;
   logic [3:0]  sync_q;
   mdm_lines_t  pin_lines, lb_lines, cur_lines, lines_q;
   logic [3:0]  delta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_wdata & WMASK;
   end

   assign loop_on  = ctl_q[CB_LOOP];
   assign auto_cts = ctl_q[CB_ACTS];

   generate
      if (AUTO_FLOW) begin : g_flow
         assign rts_act = ctl_q[CB_ARTS] ? ~rx_hold : ctl_q[CB_RTS];
         assign tx_ok   = ~auto_cts | lines_q.cts;
      end else begin : g_noflow
         assign rts_act = ctl_q[CB_RTS];
         assign tx_ok   = 1'b1;
      end
   endgenerate

   mdm_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({~dcd_n, ~ri_n, ~dsr_n, ~cts_n}),
      .q     (sync_q)
   );

   assign pin_lines = mdm_lines_t'(sync_q);
   assign lb_lines  = '{dcd: ctl_q[CB_AUXB], ri: ctl_q[CB_AUXA],
                        dsr: ctl_q[CB_DTR],  cts: ctl_q[CB_RTS]};
   assign cur_lines = loop_on ? lb_lines : pin_lines;

   mdm_delta u_delta (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur     (cur_lines),
      .clr     (sts_rd),
      .lines_q (lines_q),
      .delta_q (delta_q)
   );

   mdm_irq u_irq (
      .msi_en   (msi_en),
      .cts_ie   (cts_ie),
      .auto_cts (auto_cts),
      .delta    (delta_q),
      .irq      (irq)
   );

   assign ctl_rdata = {ctl_q[7:2], rts_act, ctl_q[CB_DTR]};
   assign sts_rdata = {lines_q, delta_q};

   assign dtr_n    = loop_on | ~ctl_q[CB_DTR];
   assign rts_n    = loop_on | ~rts_act;
   assign txd_pin  = loop_on | txd_core;
   assign rxd_core = loop_on ? txd_core : rxd_pin;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] ctl_rdata,
   input logic [7:0] sts_rdata,
   input logic       sts_rd,
   input logic       msi_en,
   input logic       irq,
   input logic       tx_ok,
   input logic       dtr_n,
   input logic       rts_n,
   input logic       txd_pin,
   input logic       txd_core,
   input logic       rxd_core
);
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_rd |=> ((sts_rdata[3:0] & $past(sts_rdata[3:0])) == $past(sts_rdata[3:0]))); // R7

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !msi_en |-> !irq); // R9

   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|sts_rdata[3:0])); // R9

   AST_LB_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[4] |-> (dtr_n && rts_n && txd_pin && (rxd_core == txd_core))); // R4

   AST_LB_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[4] && !ctl_rdata[6] && $past(ctl_rdata[4]) && !$past(ctl_rdata[6]))
      |-> (sts_rdata[7:4] == {$past(ctl_rdata[3]), $past(ctl_rdata[2]),
                              $past(ctl_rdata[0]), $past(ctl_rdata[1])})); // R5

   AST_TXOK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[7] |-> tx_ok); // R12
endmodule

bind modem_ctl_lb mdm_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_rdata (ctl_rdata),
   .sts_rdata (sts_rdata),
   .sts_rd    (sts_rd),
   .msi_en    (msi_en),
   .irq       (irq),
   .tx_ok     (tx_ok),
   .dtr_n     (dtr_n),
   .rts_n     (rts_n),
   .txd_pin   (txd_pin),
   .txd_core  (txd_core),
   .rxd_core  (rxd_core)
);

// File: tb/sim_modem_ctl_lb.sv
`timescale 1ns/1ps
module sim_modem_ctl_lb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 0, sts_rd = 0, msi_en = 0, cts_ie = 0, rx_hold = 0;
   logic txd_core = 1, rxd_pin = 1;
   logic [7:0] ctl_wdata = '0;
   logic [3:0] pins = 4'hF;            // {dcd_n, ri_n, dsr_n, cts_n}
   logic [7:0] ctl_rdata, sts_rdata;
   logic rxd_core, txd_pin, dtr_n, rts_n, irq, tx_ok;

   int checks = 0, errors = 0;
   logic [7:0] m_ctl = '0;
   logic [3:0] m_lines = '0, m_delta = '0;

   always #4 clk = ~clk;   // 125 MHz

   modem_ctl_lb #(.SYNC_STAGES(2), .AUTO_FLOW(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
      .msi_en(msi_en), .cts_ie(cts_ie), .rx_hold(rx_hold),
      .txd_core(txd_core), .rxd_core(rxd_core), .txd_pin(txd_pin),
      .rxd_pin(rxd_pin), .dtr_n(dtr_n), .rts_n(rts_n),
      .cts_n(pins[0]), .dsr_n(pins[1]), .ri_n(pins[2]), .dcd_n(pins[3]),
      .irq(irq), .tx_ok(tx_ok)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] lines_of(input logic [7:0] c, input logic [3:0] p);
      return c[4] ? {c[3], c[2], c[0], c[1]} : ~p;
   endfunction

   function automatic logic [3:0] evt_of(input logic [3:0] o, input logic [3:0] n);
      return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
   endfunction

   function automatic logic rts_of(input logic [7:0] c, input logic hold);
      return c[6] ? ~hold : c[1];
   endfunction

   function automatic logic irq_of(input logic [3:0] d, input logic [7:0] c,
                                   input logic en, input logic cie);
      return en & ((d[0] & (~c[7] | cie)) | (|d[3:1]));
   endfunction

   task automatic track();
      logic [3:0] n;
      n = lines_of(m_ctl, pins);
      m_delta = m_delta | evt_of(m_lines, n);
      m_lines = n;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic check_all();
      logic r;
      r = rts_of(m_ctl, rx_hold);
      chk("R2 control readback", ctl_rdata, {m_ctl[7:2], r, m_ctl[0]});
      chk("R5/R6 status lines", {4'h0, sts_rdata[7:4]}, {4'h0, m_lines});
      chk("R7/R10 change flags", {4'h0, sts_rdata[3:0]}, {4'h0, m_delta});
      chk("R9 irq", {7'h0, irq}, {7'h0, irq_of(m_delta, m_ctl, msi_en, cts_ie)});
      chk("R3/R5 dtr_n", {7'h0, dtr_n}, {7'h0, m_ctl[4] | ~m_ctl[0]});
      chk("R3/R5/R11 rts_n", {7'h0, rts_n}, {7'h0, m_ctl[4] | ~r});
      chk("R3/R4 txd_pin", {7'h0, txd_pin}, {7'h0, m_ctl[4] | txd_core});
      chk("R3/R4 rxd_core", {7'h0, rxd_core}, {7'h0, m_ctl[4] ? txd_core : rxd_pin});
      chk("R12 tx_ok", {7'h0, tx_ok}, {7'h0, ~m_ctl[7] | m_lines[0]});
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wr = 1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 0;
      m_ctl = v & 8'hDF;
      track();
      settle();
   endtask

   task automatic set_pins(input logic [3:0] v);
      pins = v;
      track();
      settle();
   endtask

   task automatic rd_sts();
      sts_rd = 1;
      @(negedge clk);
      sts_rd = 0;
      m_delta = '0;
      settle();
   endtask

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset ctl", ctl_rdata, 8'h00);
      chk("R1 reset sts", sts_rdata, 8'h00);
      chk("R1 reset pins", {6'h0, dtr_n, rts_n}, 8'h03);
      chk("R1 reset irq", {7'h0, irq}, 8'h00);

      // R2 reserved bit and live RTS under auto-RTS
      wr_ctl(8'hFF); check_all();
      chk("R2 bit5 reads 0", {7'h0, ctl_rdata[5]}, 8'h00);
      wr_ctl(8'h00); rd_sts(); check_all();

      // R7 ring indicator: inactive->active no flag, active->inactive flag
      set_pins(4'b1011); check_all();
      chk("R7 RI rise no flag", {7'h0, sts_rdata[2]}, 8'h00);
      set_pins(4'b1111); check_all();
      chk("R7 RI trailing flag", {7'h0, sts_rdata[2]}, 8'h01);
      rd_sts(); check_all();
      chk("R8 flags cleared", {4'h0, sts_rdata[3:0]}, 8'h00);

      // R9 R10 auto-CTS gating of the CTS flag
      msi_en = 1; cts_ie = 0;
      wr_ctl(8'h80);
      set_pins(4'b1110); check_all();
      chk("R10 CTS flag under auto-CTS", {7'h0, sts_rdata[0]}, 8'h01);
      chk("R9 irq held off", {7'h0, irq}, 8'h00);
      chk("R12 tx_ok with CTS active", {7'h0, tx_ok}, 8'h01);
      cts_ie = 1; #1;
      chk("R9 irq with cts_ie", {7'h0, irq}, 8'h01);
      rd_sts();
      set_pins(4'b1111); check_all();
      chk("R12 tx_ok with CTS idle", {7'h0, tx_ok}, 8'h00);
      rd_sts();

      // R4 R5 loopback ignores pins and mirrors control
      wr_ctl(8'h1D); check_all();
      rxd_pin = 0; txd_core = 1; #1;
      chk("R4 rxd_pin ignored", {7'h0, rxd_core}, 8'h01);
      set_pins(4'b0000); check_all();
      chk("R5 pins ignored", {4'h0, sts_rdata[7:4]}, 8'h0E);
      wr_ctl(8'h00); rd_sts(); check_all();

      // random mix
      for (int i = 0; i < 400; i++) begin
         case ($urandom % 4)
            0: wr_ctl(8'($urandom));
            1: set_pins(4'($urandom));
            2: rd_sts();
            default: begin
               msi_en = 1'($urandom); cts_ie = 1'($urandom);
               rx_hold = 1'($urandom); txd_core = 1'($urandom);
               rxd_pin = 1'($urandom);
               settle();
            end
         endcase
         check_all();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule